// File: doc/BRIEF.md
# Counter Overflow Summary and Counter-Access Legality

This block sits beside the hardware performance counters of a processor core. It gathers one overflow flag per counter from the event-select words, gates each flag with the matching bit of the counter-enable register and presents the result as a 32-bit read-only summary word. The summary is the value that software reads to learn which enabled counters have wrapped. It also gives a constant mask of the programmable counters that exist, worked out from the counter-count parameter.

The same block decides whether a CSR address, as seen by the decode stage, would raise an illegal-instruction exception. The extension-enable bit guards the summary register and the upper event-select words. The availability mask guards the programmable counter reads. The cycle, time and retired-instruction counters are always allowed.

The legality flag is combinational, so decode can use it in the same cycle. The summary word is registered and follows its inputs with one cycle of latency. None of the interfaces carry a stream, so every pin is a plain level signal with no handshake.

Top module: `pmu_ovf_status`

## Requirements
- R1: The summary register address 0xDA0 gives `access_illegal`=1 when `ext_en`=0 and 0 when `ext_en`=1.
- R2: Bits 2:0 of `ovf_summary` are always 0.
- R3: For i in 3..31, bit i of `ovf_summary` equals (overflow flag of counter i AND `cnt_enable[i]`), taken from the inputs present at the previous rising clock edge.
- R4: Counter i's event word is `evtsel_flat[i*XLEN +: XLEN]`. Its overflow flag is the word's most significant bit: bit 31 when XLEN=32 (the word is then the upper event-select half) and bit 63 when XLEN=64. No other bit of the word has any effect.
- R5: `avail_mask` has ones exactly in bits 3 through N_CTR+2 and zeros elsewhere. N_CTR above 29 is rejected at elaboration.
- R6: With N_CTR=29, `avail_mask` is 0xFFFFFFF8.
- R7: The fixed counter addresses 0xC00, 0xC01, 0xC02 and their high halves 0xC80, 0xC81, 0xC82 always give `access_illegal`=0.
- R8: A counter address 0xC03..0xC1F or 0xC83..0xC9F, whose index is addr[4:0], gives `access_illegal`=1 when N_CTR=0 or when the index's `avail_mask` bit is 0, and 0 otherwise.
- R9: The upper event-select addresses 0x723..0x73F give `access_illegal`=1 exactly when `ext_en`=0.
- R10: Every address not covered by R1, R7, R8 or R9 gives `access_illegal`=0.
- R11: While `rst_n` is low, and after it, until the first capturing edge, `ovf_summary` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the summary register |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_en | input | 1 | Overflow/filtering extension enabled |
| cnt_enable | input | 32 | Counter-enable register, one bit per counter |
| evtsel_flat | input | 32*XLEN | Event-select words, counter i at bits i*XLEN +: XLEN |
| csr_addr | input | 12 | CSR address under decode |
| ovf_summary | output | 32 | Registered overflow summary word |
| avail_mask | output | 32 | Programmable counters that exist |
| access_illegal | output | 1 | Access to csr_addr raises illegal instruction |

## Verification
The bench builds three copies: N_CTR=29 with XLEN=64, N_CTR=5 with XLEN=32, and N_CTR=0 with XLEN=32. The first copy reaches the full mask that must not collapse to zero. The second puts a mask edge inside the counter range, so indices just above and below N_CTR+2 can be tested. The third covers the case where no programmable counter exists. The two XLEN values put the flag at both most-significant-bit positions, and random low bits show that the rest of each word has no effect.

// File: rtl/pmu_ovf_pkg.sv
package pmu_ovf_pkg;
  localparam int unsigned NUM_SLOTS   = 32;
  localparam int unsigned FIXED_CNT   = 3;
  localparam int unsigned MAX_PROG    = NUM_SLOTS - FIXED_CNT;
  localparam int unsigned ADDR_W      = 12;

  localparam logic [ADDR_W-1:0] SUMMARY_ADDR = 12'hDA0;
  localparam logic [ADDR_W-1:0] EVH_LO_ADDR  = 12'h723;
  localparam logic [ADDR_W-1:0] EVH_HI_ADDR  = 12'h73F;
  localparam logic [6:0]        CTR_LO_PAGE  = 7'h60;
  localparam logic [6:0]        CTR_HI_PAGE  = 7'h64;

  // ones in bits FIXED_CNT .. FIXED_CNT+n-1, computed wide so n=29 survives
  function automatic logic [NUM_SLOTS-1:0] avail_mask_f(input int unsigned n);
    logic [63:0] m;
    m = (64'd1 << (n + FIXED_CNT)) - 64'd1;
    m = m & ~((64'd1 << FIXED_CNT) - 64'd1);
    return m[NUM_SLOTS-1:0];
  endfunction
endpackage

// File: rtl/ovf_flag_extract.sv
module ovf_flag_extract
  import pmu_ovf_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [NUM_SLOTS*XLEN-1:0] evtsel_flat,
  output logic [NUM_SLOTS-1:0]      flags
);
  localparam int unsigned FLAG_POS = XLEN - 1;

  if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
    $error("XLEN must be 32 or 64");
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    assign flags[i] = evtsel_flat[i*XLEN + FLAG_POS];
  end
endmodule

// File: rtl/ovf_summary_reg.sv
module ovf_summary_reg
  import pmu_ovf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] flags,
  input  logic [NUM_SLOTS-1:0] cnt_enable,
  output logic [NUM_SLOTS-1:0] summary_q
);
  localparam logic [NUM_SLOTS-1:0] PROG_BITS = ~((NUM_SLOTS)'((1 << FIXED_CNT) - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) summary_q <= '0;
    else        summary_q <= flags & cnt_enable & PROG_BITS;
  end

  a_r2_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    summary_q[FIXED_CNT-1:0] == '0);

  a_r3_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 ((summary_q & ~$past(cnt_enable)) == '0));

  a_r3_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 ((summary_q & ~$past(flags)) == '0));
endmodule

// File: rtl/csr_access_check.sv
module csr_access_check
  import pmu_ovf_pkg::*;
#(
  parameter int unsigned N_CTR = 29
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_en,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [NUM_SLOTS-1:0] avail,
  output logic              illegal
);
  logic       hit_summary, hit_evh, hit_ctr, is_fixed;
  logic [4:0] idx;

  always_comb begin
    idx         = csr_addr[4:0];
    hit_summary = (csr_addr == SUMMARY_ADDR);
    hit_evh     = (csr_addr >= EVH_LO_ADDR) && (csr_addr <= EVH_HI_ADDR);
    hit_ctr     = (csr_addr[11:5] == CTR_LO_PAGE) || (csr_addr[11:5] == CTR_HI_PAGE);
    is_fixed    = (idx < 5'(FIXED_CNT));
    illegal     = ((hit_summary || hit_evh) && !ext_en) ||
                  (hit_ctr && !is_fixed && ((N_CTR == 0) || !avail[idx]));
  end

  a_r1_summary_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr == 12'hDA0) |-> (illegal == !ext_en));

  a_r7_fixed_pass: assert property (@(posedge clk) disable iff (!rst_n)
    ((csr_addr[11:2] == 10'h300 || csr_addr[11:2] == 10'h320) && csr_addr[1:0] != 2'b11)
      |-> !illegal);

  a_r9_evh_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr[11:5] == 7'h39 && csr_addr[4:0] >= 5'd3) |-> (illegal == !ext_en));
endmodule

// File: rtl/pmu_ovf_status.sv
module pmu_ovf_status
  import pmu_ovf_pkg::*;
#(
  parameter int unsigned N_CTR = 29,
  parameter int unsigned XLEN  = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ext_en,
  input  logic [31:0]               cnt_enable,
  input  logic [32*XLEN-1:0]        evtsel_flat,
  input  logic [11:0]               csr_addr,
  output logic [31:0]               ovf_summary,
  output logic [31:0]               avail_mask,
  output logic                      access_illegal
);
  localparam logic [NUM_SLOTS-1:0] AVAIL = avail_mask_f(N_CTR);

  if (N_CTR > MAX_PROG) begin : g_bad_n
    $error("N_CTR exceeds the programmable counter slots");
  end

  logic [NUM_SLOTS-1:0] flags;

  assign avail_mask = AVAIL;

  ovf_flag_extract #(.XLEN(XLEN)) u_extract (
    .evtsel_flat (evtsel_flat),
    .flags       (flags)
  );

  ovf_summary_reg u_summary (
    .clk        (clk),
    .rst_n      (rst_n),
    .flags      (flags),
    .cnt_enable (cnt_enable),
    .summary_q  (ovf_summary)
  );

  csr_access_check #(.N_CTR(N_CTR)) u_check (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_en   (ext_en),
    .csr_addr (csr_addr),
    .avail    (AVAIL),
    .illegal  (access_illegal)
  );
endmodule

// File: tb/pmu_ovf_status_tb_top.sv
`timescale 1ns/1ps
module pmu_ovf_status_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_en = 1'b0;
  logic [31:0] cnt_en = '0;
  logic [32*64-1:0] ev64 = '0;
  logic [32*32-1:0] ev32 = '0;
  logic [11:0] addr = '0;

  logic [31:0] sum_a, sum_b, sum_c, msk_a, msk_b, msk_c;
  logic        ill_a, ill_b, ill_c;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  pmu_ovf_status #(.N_CTR(29), .XLEN(64)) dut_i (
    .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .cnt_enable(cnt_en),
    .evtsel_flat(ev64), .csr_addr(addr),
    .ovf_summary(sum_a), .avail_mask(msk_a), .access_illegal(ill_a));

  pmu_ovf_status #(.N_CTR(5), .XLEN(32)) dut_n5 (
    .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .cnt_enable(cnt_en),
    .evtsel_flat(ev32), .csr_addr(addr),
    .ovf_summary(sum_b), .avail_mask(msk_b), .access_illegal(ill_b));

  pmu_ovf_status #(.N_CTR(0), .XLEN(32)) dut_n0 (
    .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .cnt_enable(cnt_en),
    .evtsel_flat(ev32), .csr_addr(addr),
    .ovf_summary(sum_c), .avail_mask(msk_c), .access_illegal(ill_c));

  function automatic logic [31:0] exp_mask(int n);
    logic [31:0] m = '0;
    for (int i = 3; i < 3 + n; i++) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [31:0] exp_sum(logic [31:0] f, logic [31:0] e);
    logic [31:0] s = '0;
    for (int i = 3; i < 32; i++) s[i] = f[i] & e[i];
    return s;
  endfunction

  function automatic logic exp_ill(logic [11:0] a, logic x, int n);
    logic [31:0] m = exp_mask(n);
    int k = int'(a[4:0]);
    if (a == 12'hDA0) return !x;
    if (a >= 12'h723 && a <= 12'h73F) return !x;
    if ((a >= 12'hC00 && a <= 12'hC1F) || (a >= 12'hC80 && a <= 12'hC9F)) begin
      if (k < 3) return 1'b0;
      return (n == 0) || !m[k];
    end
    return 1'b0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h addr=%h ext=%0b", req, act, exp, addr, ext_en);
    end
  endtask

  task automatic set_words(logic [31:0] f, bit lows_ones);
    for (int i = 0; i < 32; i++) begin
      logic [63:0] w64;
      logic [31:0] w32;
      w64 = lows_ones ? '1 : {$urandom, $urandom};
      w32 = lows_ones ? '1 : $urandom;
      w64[63] = f[i];
      w32[31] = f[i];
      ev64[i*64 +: 64] = w64;
      ev32[i*32 +: 32] = w32;
    end
  endtask

  task automatic check_ill(string req);
    #1;
    chk(req, {31'd0, ill_a}, {31'd0, exp_ill(addr, ext_en, 29)});
    chk(req, {31'd0, ill_b}, {31'd0, exp_ill(addr, ext_en, 5)});
    chk(req, {31'd0, ill_c}, {31'd0, exp_ill(addr, ext_en, 0)});
  endtask

  task automatic check_sum(string req, logic [31:0] f, logic [31:0] e);
    @(posedge clk);
    @(negedge clk);
    chk(req, sum_a, exp_sum(f, e));
    chk(req, sum_b, exp_sum(f, e));
    chk(req, sum_c, exp_sum(f, e));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] f;
    void'($urandom(32'd1234));
    // R11: reset holds summary at zero despite live inputs
    f = '1;
    cnt_en = '1;
    set_words(f, 1'b0);
    repeat (3) @(negedge clk);
    chk("R11", sum_a, 32'd0);
    chk("R11", sum_b, 32'd0);
    chk("R11", sum_c, 32'd0);
    rst_n = 1'b1;

    // R5 / R6: masks
    chk("R6", msk_a, 32'hFFFF_FFF8);
    chk("R5", msk_a, exp_mask(29));
    chk("R5", msk_b, 32'h0000_00F8);
    chk("R5", msk_c, 32'h0);

    // R3 / R2: all flags and enables set
    check_sum("R3", f, cnt_en);
    // R4: low bits all ones, flag clear -> nothing
    @(negedge clk);
    set_words(32'd0, 1'b1);
    check_sum("R4", 32'd0, cnt_en);
    // R3: enables cleared block flags
    set_words(32'hFFFF_FFFF, 1'b0);
    cnt_en = 32'h0;
    check_sum("R3", 32'hFFFF_FFFF, 32'h0);
    // R2: bits 0..2 flagged and enabled only
    set_words(32'h7, 1'b0);
    cnt_en = 32'h7;
    check_sum("R2", 32'h7, 32'h7);

    // directed addresses
    for (int x = 0; x < 2; x++) begin
      ext_en = x[0];
      addr = 12'hDA0; check_ill("R1");
      addr = 12'h723; check_ill("R9");
      addr = 12'h73F; check_ill("R9");
      addr = 12'h722; check_ill("R10");
      addr = 12'h740; check_ill("R10");
      addr = 12'hC00; check_ill("R7");
      addr = 12'hC01; check_ill("R7");
      addr = 12'hC02; check_ill("R7");
      addr = 12'hC82; check_ill("R7");
      addr = 12'hC03; check_ill("R8");
      addr = 12'hC07; check_ill("R8");
      addr = 12'hC08; check_ill("R8");
      addr = 12'hC9F; check_ill("R8");
      addr = 12'hC1F; check_ill("R8");
      addr = 12'hC20; check_ill("R10");
      addr = 12'hB03; check_ill("R10");
    end
    // explicit N=5 boundary expectations
    ext_en = 1'b1;
    addr = 12'hC07; #1; chk("R8", {31'd0, ill_b}, 32'd0);
    addr = 12'hC88; #1; chk("R8", {31'd0, ill_b}, 32'd1);
    addr = 12'hC1F; #1; chk("R8", {31'd0, ill_a}, 32'd0);
    addr = 12'hC03; #1; chk("R8", {31'd0, ill_c}, 32'd1);
    ext_en = 1'b0;
    addr = 12'hDA0; #1; chk("R1", {31'd0, ill_a}, 32'd1);

    // constrained random
    for (int it = 0; it < 400; it++) begin
      int sel;
      @(negedge clk);
      f = $urandom;
      cnt_en = $urandom;
      ext_en = 1'($urandom);
      set_words(f, 1'b0);
      sel = int'($urandom % 5);
      case (sel)
        0: addr = {7'h60, 5'($urandom)};
        1: addr = {7'h64, 5'($urandom)};
        2: addr = {7'h39, 5'($urandom)};
        3: addr = 12'hDA0;
        default: addr = 12'($urandom);
      endcase
      check_ill("R8");
      check_sum("R3", f, cnt_en);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule